// File: doc/BRIEF.md
# Indexed Register Bank with Command Mailboxes and Shared Payload RAM

This block is a 16-bit register bank that a host CPU reaches through just two bus locations. One is an index port: a write there selects a register. The other is a data port: each read or write there goes to the register that the stored index selects. The bank sits between the host and a coprocessor. It holds the following:

- fixed identification words;
- a build date and build time, both in BCD;
- a fan speed reading;
- two scratch words;
- two command mailboxes, one for each direction;
- a shared payload RAM of 2048 words.

The host moves payload through the data port in bursts. When the stored index selects the RAM, each data-port access touches the word under an internal pointer and then advances that pointer. To send a message, the host writes the payload first and then writes the command code into the outbound mailbox. That mailbox write rings a doorbell on the coprocessor side. To receive, the host sees its own doorbell and reads the inbound mailbox, which clears the doorbell. It then drains the payload. The coprocessor has its own port for the RAM, a registered command output with an acknowledge, and a reply strobe.

The fan reading is the number of debounced rising edges of the fan sense input counted over a one-second gate. The gate length is `CLK_HZ` clock cycles. The register changes only at the end of each gate.

Top module: `mbox_regbank`

## Requirements
- R1: After reset, both doorbells are low, `host_rvalid` is low, the stored index is 0x0000 (so a data-port read returns `SIG_A`), both scratch words read 0 and the fan reading is 0.
- R2: Host ports and read timing:
  - `host_port`=0 with `host_wr` stores `host_wdata` as the index. `host_port`=1 reads or writes the selected register.
  - A data-port read returns its value on `host_rdata`, with `host_rvalid` high, in the cycle after `host_rd`.
  - Indices 0x0000 and 0x0001 read `SIG_A` and `SIG_B`, and 0x0002 reads `HW_REV`.
- R3: Index 0x0030 and index 0x0031 are read/write scratch words. Data-port writes to read-only indices (0x0000–0x0002, 0x0006, 0x0010, 0x0021–0x0024) and to unmapped indices are ignored. Unmapped indices read 0.
- R4: Shared RAM indexing and bursts:
  - Index 0x8000 selects the shared RAM, and every index-port write of 0x8000 resets the RAM pointer to word 0.
  - Each data-port access while 0x8000 is selected reads or writes the word at the pointer, then advances the pointer by one.
- R5: The RAM pointer wraps from the last word (0x7FF by default) back to word 0.
- R6: The coprocessor port reads RAM words written by the host, with one cycle of latency. Words the coprocessor writes are returned by later host burst reads.
- R7: Outbound mailbox and doorbell:
  - A host data-port write to index 0x0005 stores the command on `cp_cmd` and sets `cp_doorbell`.
  - `cp_doorbell` stays set until a `cp_cmd_ack` cycle clears it. If a set and a clear fall in the same cycle, the set wins.
  - The host can read back index 0x0005.
- R8: Inbound mailbox and doorbell:
  - `cp_reply_wr` stores `cp_reply_data` as the inbound mailbox (index 0x0006) and sets `host_doorbell`.
  - A host data-port read of 0x0006 returns the reply and clears the flag. If a set and a clear fall in the same cycle, the set wins.
- R9: Index 0x0010 reads the count of debounced `fan_sense` rising edges seen in the previous gate of `CLK_HZ` cycles. The value changes only at the end of a gate.
- R10: A `fan_sense` high pulse shorter than `DEB_CYCLES` clock cycles is not counted.
- R11: Date and time registers:
  - Index 0x0022 reads the 4-digit BCD year.
  - Index 0x0021 reads the BCD month in bits 15:8 and the BCD day in bits 7:0.
  - Index 0x0024 reads the BCD hours in bits 7:0.
  - Index 0x0023 reads the BCD minutes in bits 15:8 and the BCD seconds in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_port | input | 1 | 0 selects the index port, 1 selects the data port |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (data port only) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, valid while host_rvalid is high |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| host_doorbell | output | 1 | Reply waiting in the inbound mailbox |
| cp_ram_en | input | 1 | Coprocessor RAM access enable |
| cp_ram_we | input | 1 | Coprocessor RAM write enable |
| cp_ram_addr | input | $clog2(RAM_WORDS) | Coprocessor RAM word address |
| cp_ram_wdata | input | 16 | Coprocessor RAM write data |
| cp_ram_rdata | output | 16 | Coprocessor RAM read data, one cycle after the access |
| cp_cmd | output | 16 | Current outbound command word |
| cp_doorbell | output | 1 | New command waiting for the coprocessor |
| cp_cmd_ack | input | 1 | Coprocessor has taken the command; clears cp_doorbell |
| cp_reply_wr | input | 1 | Coprocessor posts a reply |
| cp_reply_data | input | 16 | Reply command word |
| fan_sense | input | 1 | Asynchronous fan tachometer input |

## Verification
The assertions assume two things about the inputs:
- `host_wr` and `host_rd` are never high together, so the host makes at most one access per cycle.
- `fan_sense` edges are far enough apart for the debouncer to settle.

The stimulus keeps within these limits. Every host access is a single one-cycle strobe followed by an idle cycle. Fan pulses are either well above or well below the debounce length, and they are placed away from gate boundaries. Burst reads only touch RAM words that were written earlier, so no read depends on uninitialised storage.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam logic [15:0] IX_SIG_A   = 16'h0000;
  localparam logic [15:0] IX_SIG_B   = 16'h0001;
  localparam logic [15:0] IX_REV     = 16'h0002;
  localparam logic [15:0] IX_MB_OUT  = 16'h0005;
  localparam logic [15:0] IX_MB_IN   = 16'h0006;
  localparam logic [15:0] IX_TACH    = 16'h0010;
  localparam logic [15:0] IX_DATE_LO = 16'h0021;
  localparam logic [15:0] IX_DATE_HI = 16'h0022;
  localparam logic [15:0] IX_TIME_LO = 16'h0023;
  localparam logic [15:0] IX_TIME_HI = 16'h0024;
  localparam logic [15:0] IX_SCR0    = 16'h0030;
  localparam logic [15:0] IX_SCR1    = 16'h0031;
  localparam logic [15:0] IX_RAM     = 16'h8000;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_SIG_A, SEL_SIG_B, SEL_REV, SEL_MB_OUT, SEL_MB_IN,
    SEL_TACH, SEL_DATE_LO, SEL_DATE_HI, SEL_TIME_LO, SEL_TIME_HI,
    SEL_SCR0, SEL_SCR1, SEL_RAM
  } reg_sel_e;

  // Map a stored index to the register it selects.
  function automatic reg_sel_e decode_index(input logic [15:0] ix);
    case (ix)
      IX_SIG_A:   return SEL_SIG_A;
      IX_SIG_B:   return SEL_SIG_B;
      IX_REV:     return SEL_REV;
      IX_MB_OUT:  return SEL_MB_OUT;
      IX_MB_IN:   return SEL_MB_IN;
      IX_TACH:    return SEL_TACH;
      IX_DATE_LO: return SEL_DATE_LO;
      IX_DATE_HI: return SEL_DATE_HI;
      IX_TIME_LO: return SEL_TIME_LO;
      IX_TIME_HI: return SEL_TIME_HI;
      IX_SCR0:    return SEL_SCR0;
      IX_SCR1:    return SEL_SCR1;
      IX_RAM:     return SEL_RAM;
      default:    return SEL_NONE;
    endcase
  endfunction

  // Next pointer value in a ring of 'depth' words.
  function automatic int wrap_inc(input int p, input int depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  // Saturating 16-bit increment for event counters.
  function automatic logic [15:0] sat_inc16(input logic [15:0] v);
    return (v == 16'hFFFF) ? v : v + 16'd1;
  endfunction

endpackage

// File: rtl/mbox_index_ctrl.sv
module mbox_index_ctrl import mbox_pkg::*; #(
  parameter int RAM_WORDS = 2048
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         host_port,
  input  logic                         host_wr,
  input  logic                         host_rd,
  input  logic [15:0]                  host_wdata,
  output reg_sel_e                     sel,
  output logic [$clog2(RAM_WORDS)-1:0] ptr,
  output logic                         ram_step
);
  localparam int AW = $clog2(RAM_WORDS);

  logic [15:0] idx_q;
  logic        idx_wr;
  logic        data_acc;

  assign idx_wr   = host_wr && !host_port;
  assign data_acc = host_port && (host_wr || host_rd);
  assign sel      = decode_index(idx_q);
  assign ram_step = data_acc && (sel == SEL_RAM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      ptr   <= '0;
    end else if (idx_wr) begin
      idx_q <= host_wdata;
      if (host_wdata == IX_RAM) ptr <= '0;
    end else if (ram_step) begin
      ptr <= AW'(wrap_inc(32'(ptr), RAM_WORDS));
    end
  end
endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram #(
  parameter int WORDS = 2048,
  parameter int W     = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     a_en,
  input  logic                     a_we,
  input  logic [$clog2(WORDS)-1:0] a_addr,
  input  logic [W-1:0]             a_wdata,
  output logic [W-1:0]             a_rdata,
  input  logic                     b_en,
  input  logic                     b_we,
  input  logic [$clog2(WORDS)-1:0] b_addr,
  input  logic [W-1:0]             b_wdata,
  output logic [W-1:0]             b_rdata
);
  logic [W-1:0] mem [WORDS];

  // Host port (a) is written last, so it wins a same-address collision.
  always_ff @(posedge clk) begin
    if (b_en && b_we) mem[b_addr] <= b_wdata;
    if (a_en && a_we) mem[a_addr] <= a_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      if (a_en && !a_we) a_rdata <= mem[a_addr];
      if (b_en && !b_we) b_rdata <= mem[b_addr];
    end
  end
endmodule

// File: rtl/mbox_tach.sv
module mbox_tach import mbox_pkg::*; #(
  parameter int CLK_HZ     = 100_000_000,
  parameter int DEB_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fan_in,
  output logic [15:0] rps,
  output logic        gate_end,
  output logic        edge_pulse
);
  localparam int GW  = $clog2(CLK_HZ);
  localparam int DBW = $clog2(DEB_CYCLES) + 1;

  logic           s1, s2, stable_q;
  logic [DBW-1:0] deb_cnt;
  logic [GW-1:0]  gate_cnt;
  logic [15:0]    edge_cnt;
  logic           flip;

  assign flip       = (s2 != stable_q) && (deb_cnt == DBW'(DEB_CYCLES - 1));
  assign edge_pulse = flip && s2;
  assign gate_end   = (gate_cnt == GW'(CLK_HZ - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1       <= 1'b0;
      s2       <= 1'b0;
      stable_q <= 1'b0;
      deb_cnt  <= '0;
    end else begin
      s1 <= fan_in;
      s2 <= s1;
      if (s2 == stable_q) begin
        deb_cnt <= '0;
      end else if (flip) begin
        stable_q <= s2;
        deb_cnt  <= '0;
      end else begin
        deb_cnt <= deb_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_cnt <= '0;
      edge_cnt <= '0;
      rps      <= '0;
    end else if (gate_end) begin
      gate_cnt <= '0;
      edge_cnt <= '0;
      rps      <= edge_pulse ? sat_inc16(edge_cnt) : edge_cnt;
    end else begin
      gate_cnt <= gate_cnt + 1'b1;
      if (edge_pulse) edge_cnt <= sat_inc16(edge_cnt);
    end
  end
endmodule

// File: rtl/mbox_regbank.sv
module mbox_regbank import mbox_pkg::*; #(
  parameter int          RAM_WORDS  = 2048,
  parameter int          CLK_HZ     = 100_000_000,
  parameter int          DEB_CYCLES = 4,
  parameter logic [15:0] SIG_A      = 16'hC5A9,
  parameter logic [15:0] SIG_B      = 16'h3E71,
  parameter logic [15:0] HW_REV     = 16'h0002,
  parameter logic [15:0] DATE_HI    = 16'h2024,
  parameter logic [15:0] DATE_LO    = 16'h0715,
  parameter logic [15:0] TIME_HI    = 16'h0013,
  parameter logic [15:0] TIME_LO    = 16'h4527
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         host_port,
  input  logic                         host_wr,
  input  logic                         host_rd,
  input  logic [15:0]                  host_wdata,
  output logic [15:0]                  host_rdata,
  output logic                         host_rvalid,
  output logic                         host_doorbell,
  input  logic                         cp_ram_en,
  input  logic                         cp_ram_we,
  input  logic [$clog2(RAM_WORDS)-1:0] cp_ram_addr,
  input  logic [15:0]                  cp_ram_wdata,
  output logic [15:0]                  cp_ram_rdata,
  output logic [15:0]                  cp_cmd,
  output logic                         cp_doorbell,
  input  logic                         cp_cmd_ack,
  input  logic                         cp_reply_wr,
  input  logic [15:0]                  cp_reply_data,
  input  logic                         fan_sense
);
  localparam int AW = $clog2(RAM_WORDS);

  reg_sel_e    sel;
  logic [AW-1:0] ptr;
  logic        ram_step;
  logic        data_wr, data_rd;
  logic        mbout_wr, host_bell_clr, scr0_wr, scr1_wr;
  logic [15:0] scr0_q, scr1_q, mb_in_q, tach_rps;
  logic        gate_end, fan_edge;
  logic [15:0] reg_val, reg_rd_q, ram_rdata;
  logic        rd_ram_q;

  mbox_index_ctrl #(.RAM_WORDS(RAM_WORDS)) u_index (
    .clk(clk), .rst_n(rst_n), .host_port(host_port), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .sel(sel), .ptr(ptr),
    .ram_step(ram_step)
  );

  assign data_wr       = host_port && host_wr;
  assign data_rd       = host_port && host_rd;
  assign mbout_wr      = data_wr && (sel == SEL_MB_OUT);
  assign host_bell_clr = data_rd && (sel == SEL_MB_IN);
  assign scr0_wr       = data_wr && (sel == SEL_SCR0);
  assign scr1_wr       = data_wr && (sel == SEL_SCR1);

  mbox_dpram #(.WORDS(RAM_WORDS), .W(16)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .a_en(ram_step), .a_we(data_wr), .a_addr(ptr), .a_wdata(host_wdata),
    .a_rdata(ram_rdata),
    .b_en(cp_ram_en), .b_we(cp_ram_we), .b_addr(cp_ram_addr),
    .b_wdata(cp_ram_wdata), .b_rdata(cp_ram_rdata)
  );

  mbox_tach #(.CLK_HZ(CLK_HZ), .DEB_CYCLES(DEB_CYCLES)) u_tach (
    .clk(clk), .rst_n(rst_n), .fan_in(fan_sense), .rps(tach_rps),
    .gate_end(gate_end), .edge_pulse(fan_edge)
  );

  // Scratch words and mailboxes; a set beats a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scr0_q        <= '0;
      scr1_q        <= '0;
      cp_cmd        <= '0;
      mb_in_q       <= '0;
      cp_doorbell   <= 1'b0;
      host_doorbell <= 1'b0;
    end else begin
      if (scr0_wr) scr0_q <= host_wdata;
      if (scr1_wr) scr1_q <= host_wdata;
      if (mbout_wr) begin
        cp_cmd      <= host_wdata;
        cp_doorbell <= 1'b1;
      end else if (cp_cmd_ack) begin
        cp_doorbell <= 1'b0;
      end
      if (cp_reply_wr) begin
        mb_in_q       <= cp_reply_data;
        host_doorbell <= 1'b1;
      end else if (host_bell_clr) begin
        host_doorbell <= 1'b0;
      end
    end
  end

  always_comb begin
    case (sel)
      SEL_SIG_A:   reg_val = SIG_A;
      SEL_SIG_B:   reg_val = SIG_B;
      SEL_REV:     reg_val = HW_REV;
      SEL_MB_OUT:  reg_val = cp_cmd;
      SEL_MB_IN:   reg_val = mb_in_q;
      SEL_TACH:    reg_val = tach_rps;
      SEL_DATE_LO: reg_val = DATE_LO;
      SEL_DATE_HI: reg_val = DATE_HI;
      SEL_TIME_LO: reg_val = TIME_LO;
      SEL_TIME_HI: reg_val = TIME_HI;
      SEL_SCR0:    reg_val = scr0_q;
      SEL_SCR1:    reg_val = scr1_q;
      default:     reg_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rvalid <= 1'b0;
      rd_ram_q    <= 1'b0;
      reg_rd_q    <= '0;
    end else begin
      host_rvalid <= data_rd;
      rd_ram_q    <= data_rd && (sel == SEL_RAM);
      if (data_rd) reg_rd_q <= reg_val;
    end
  end

  assign host_rdata = rd_ram_q ? ram_rdata : reg_rd_q;

endmodule

// File: rtl/mbox_regbank_sva.sv
module mbox_regbank_sva #(
  parameter int RAM_WORDS = 2048
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         host_wr,
  input logic                         host_rd,
  input logic                         host_rvalid,
  input logic                         mbout_wr,
  input logic                         cp_cmd_ack,
  input logic                         cp_doorbell,
  input logic                         cp_reply_wr,
  input logic                         host_bell_clr,
  input logic                         host_doorbell,
  input logic                         ram_step,
  input logic [$clog2(RAM_WORDS)-1:0] ptr,
  input logic                         gate_end,
  input logic [15:0]                  tach_rps
);
  localparam int AW = $clog2(RAM_WORDS);
  localparam logic [AW-1:0] LAST = AW'(RAM_WORDS - 1);

  AST_ONE_HOST_OP: assert property (@(posedge clk) disable iff (!rst_n) !(host_wr && host_rd)); // R2
  AST_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n) host_rvalid |-> $past(host_rd)); // R2
  AST_CP_BELL_SET: assert property (@(posedge clk) disable iff (!rst_n) mbout_wr |=> cp_doorbell); // R7
  AST_CP_BELL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (cp_doorbell && !cp_cmd_ack) |=> cp_doorbell); // R7
  AST_CP_BELL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (cp_cmd_ack && !mbout_wr) |=> !cp_doorbell); // R7
  AST_HOST_BELL_SET: assert property (@(posedge clk) disable iff (!rst_n) cp_reply_wr |=> host_doorbell); // R8
  AST_HOST_BELL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (host_bell_clr && !cp_reply_wr) |=> !host_doorbell); // R8
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n) (ram_step && ptr != LAST) |=> ptr == $past(ptr) + 1'b1); // R4
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (ram_step && ptr == LAST) |=> ptr == '0); // R5
  AST_TACH_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !gate_end |=> $stable(tach_rps)); // R9
endmodule

bind mbox_regbank mbox_regbank_sva #(.RAM_WORDS(RAM_WORDS)) u_sva (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
  .host_rvalid(host_rvalid), .mbout_wr(mbout_wr), .cp_cmd_ack(cp_cmd_ack),
  .cp_doorbell(cp_doorbell), .cp_reply_wr(cp_reply_wr),
  .host_bell_clr(host_bell_clr), .host_doorbell(host_doorbell),
  .ram_step(ram_step), .ptr(ptr), .gate_end(gate_end), .tach_rps(tach_rps)
);

// File: tb/mbox_regbank_bench.sv
module mbox_regbank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RAM_WORDS  = 2048;
  localparam int AW         = $clog2(RAM_WORDS);
  localparam int GATE       = 400;
  localparam int DEB        = 3;
  // Build stamp expressed as BCD digits, assembled by field.
  localparam logic [15:0] YEAR = {4'd2, 4'd0, 4'd2, 4'd5};
  localparam logic [7:0]  MON  = {4'd1, 4'd1}, DAY = {4'd0, 4'd9};
  localparam logic [7:0]  HR   = {4'd2, 4'd1}, MIN = {4'd3, 4'd8}, SEC = {4'd5, 4'd6};
  localparam logic [15:0] SA = 16'hB00C, SB = 16'h71E3, REV = 16'h0007;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_port = 0, host_wr = 0, host_rd = 0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic host_rvalid, host_doorbell;
  logic cp_ram_en = 0, cp_ram_we = 0;
  logic [AW-1:0] cp_ram_addr = '0;
  logic [15:0] cp_ram_wdata = '0, cp_ram_rdata, cp_cmd;
  logic cp_doorbell, cp_cmd_ack = 0, cp_reply_wr = 0;
  logic [15:0] cp_reply_data = '0;
  logic fan_sense = 0;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  mbox_regbank #(
    .RAM_WORDS(RAM_WORDS), .CLK_HZ(GATE), .DEB_CYCLES(DEB),
    .SIG_A(SA), .SIG_B(SB), .HW_REV(REV),
    .DATE_HI(YEAR), .DATE_LO({MON, DAY}), .TIME_HI({8'h00, HR}), .TIME_LO({MIN, SEC})
  ) u_mbox_regbank (.*);

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pop the scoreboard whenever read data appears.
  always @(negedge clk) begin
    if (rst_n && host_rvalid) begin
      if (exp_q.size() == 0) chk("R2 unexpected rvalid", 16'h1, 16'h0);
      else chk(tag_q.pop_front(), host_rdata, exp_q.pop_front());
    end
  end

  task automatic host_op(bit port, bit wr, bit rd, logic [15:0] d);
    @(negedge clk);
    host_port = port; host_wr = wr; host_rd = rd; host_wdata = d;
    @(negedge clk);
    host_wr = 0; host_rd = 0;
  endtask
  task automatic set_idx(logic [15:0] ix); host_op(0, 1, 0, ix); endtask
  task automatic dwrite(logic [15:0] d); host_op(1, 1, 0, d); endtask
  task automatic dread(logic [15:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    host_op(1, 0, 1, 16'h0);
  endtask
  task automatic cp_read(logic [AW-1:0] a, logic [15:0] exp, string tag);
    @(negedge clk); cp_ram_en = 1; cp_ram_we = 0; cp_ram_addr = a;
    @(negedge clk); cp_ram_en = 0;
    chk(tag, cp_ram_rdata, exp);
  endtask
  task automatic cp_write(logic [AW-1:0] a, logic [15:0] d);
    @(negedge clk); cp_ram_en = 1; cp_ram_we = 1; cp_ram_addr = a; cp_ram_wdata = d;
    @(negedge clk); cp_ram_en = 0; cp_ram_we = 0;
  endtask
  task automatic fan_pulse(int hi, int lo);
    @(negedge clk); fan_sense = 1;
    repeat (hi) @(negedge clk);
    fan_sense = 0;
    repeat (lo) @(negedge clk);
  endtask
  task automatic wait_cyc(int n); while (cyc < n) @(negedge clk); endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 cp_doorbell", {15'd0, cp_doorbell}, 16'h0);
    chk("R1 host_doorbell", {15'd0, host_doorbell}, 16'h0);
    chk("R1 host_rvalid", {15'd0, host_rvalid}, 16'h0);
    dread(SA, "R1 index resets to 0");
    set_idx(16'h0030); dread(16'h0, "R1 scratch0 reset");
    set_idx(16'h0010); dread(16'h0, "R1 tach reset");
    // R9: five clean revolutions inside the first gate
    wait_cyc(20);
    for (int i = 0; i < 5; i++) fan_pulse(10, 10);
    wait_cyc(420);
    set_idx(16'h0010); dread(16'd5, "R9 tach count");
    wait_cyc(520);
    dread(16'd5, "R9 tach stable within gate");
    // R10: short glitches ignored, two real pulses counted in gate 2
    wait_cyc(560);
    for (int i = 0; i < 3; i++) fan_pulse(2, 8);
    for (int i = 0; i < 2; i++) fan_pulse(10, 10);
    for (int i = 0; i < 2; i++) fan_pulse(1, 8);
    wait_cyc(850);
    dread(16'd2, "R10 glitches not counted");
    // R2 and R11 identification and BCD stamps
    set_idx(16'h0001); dread(SB, "R2 sig B");
    set_idx(16'h0002); dread(REV, "R2 hw rev");
    set_idx(16'h0022); dread(YEAR, "R11 year");
    set_idx(16'h0021); dread({MON, DAY}, "R11 month/day");
    set_idx(16'h0024); dread({8'h00, HR}, "R11 hours");
    set_idx(16'h0023); dread({MIN, SEC}, "R11 min/sec");
    // R3 scratch, read-only, unmapped
    set_idx(16'h0030); dwrite(16'hA5A5);
    set_idx(16'h0031); dwrite(16'h5A5A);
    set_idx(16'h0030); dread(16'hA5A5, "R3 scratch0");
    set_idx(16'h0031); dread(16'h5A5A, "R3 scratch1");
    set_idx(16'h0002); dwrite(16'hFFFF); dread(REV, "R3 rev write ignored");
    set_idx(16'h0007); dwrite(16'h1234); dread(16'h0, "R3 unmapped reads 0");
    // R4 burst write, restart, burst read
    set_idx(16'h8000);
    dwrite(16'h1111); dwrite(16'h2222); dwrite(16'h3333); dwrite(16'h4444);
    set_idx(16'h8000);
    dread(16'h1111, "R4 burst w0"); dread(16'h2222, "R4 burst w1");
    dread(16'h3333, "R4 burst w2"); dread(16'h4444, "R4 burst w3");
    set_idx(16'h8000); dread(16'h1111, "R4 restart at 0");
    set_idx(16'h8000); dread(16'h1111, "R4 restart again");
    // R6 coprocessor side
    cp_read(2, 16'h3333, "R6 cp sees host word");
    cp_write(0, 16'hC0C0); cp_write(1, 16'hC1C1);
    set_idx(16'h8000);
    dread(16'hC0C0, "R6 host sees cp w0"); dread(16'hC1C1, "R6 host sees cp w1");
    dread(16'h3333, "R6 host w2 intact");
    // R7 outbound mailbox
    set_idx(16'h0005); dwrite(16'h0ACE);
    chk("R7 doorbell set", {15'd0, cp_doorbell}, 16'h1);
    chk("R7 cp_cmd", cp_cmd, 16'h0ACE);
    repeat (3) @(negedge clk);
    chk("R7 doorbell sticky", {15'd0, cp_doorbell}, 16'h1);
    dread(16'h0ACE, "R7 readback");
    cp_cmd_ack = 1; @(negedge clk); cp_cmd_ack = 0;
    chk("R7 doorbell cleared", {15'd0, cp_doorbell}, 16'h0);
    // R8 inbound mailbox
    cp_reply_data = 16'hBEEF; cp_reply_wr = 1; @(negedge clk); cp_reply_wr = 0;
    chk("R8 host doorbell set", {15'd0, host_doorbell}, 16'h1);
    set_idx(16'h0006); dwrite(16'h0000);
    chk("R8 doorbell kept after write", {15'd0, host_doorbell}, 16'h1);
    dread(16'hBEEF, "R8 reply read, write ignored");
    chk("R8 doorbell cleared by read", {15'd0, host_doorbell}, 16'h0);
    // R5 pointer wrap
    set_idx(16'h8000);
    for (int i = 0; i < RAM_WORDS - 1; i++) dwrite(16'(i));
    dwrite(16'hAAAA);
    dwrite(16'hBBBB);
    cp_read(AW'(RAM_WORDS - 1), 16'hAAAA, "R5 last word");
    cp_read('0, 16'hBBBB, "R5 wrapped to word 0");
    cp_read(5, 16'h0005, "R5 middle word");
    repeat (4) @(negedge clk);
    chk("R2 scoreboard drained", 16'(exp_q.size()), 16'h0);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule